// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a serial peripheral interface master controlled through a small register window. Software pushes 32-bit words into a four-entry transmit queue. It then writes a command word that holds the clock mode, the chip-select index, the data enables, the word length (1 to 32 bits) and a go bit. The engine shifts the word out on `mosi`, most significant bit first, and at the same time samples `miso`. When the word ends, the captured bits, right-aligned, go into a four-entry receive queue that software drains through a read port.

The serial clock comes from the system clock through a programmable half-period divider. Between words `sclk` rests at the polarity level of the current mode. One of four active-low chip selects is driven. The hardware can lower it for the length of each word, or software can hold it at a chosen level across several words. Queue misuse (a write to a full transmit queue, a word started with nothing queued, a word finished into a full receive queue, a read of an empty receive queue) sets sticky flags, and each flag is cleared by writing 1 to it.

Top module: `spi_master_regs`

## Requirements
- R1: After reset the command register reads 0, the transfer status reads 0, the FIFO status reads 0x5 (both queues empty), all `csN` are high, and `sclk` and `mosi` are low.
- R2: A write to offset 0x108 pushes a word into the transmit queue and a read of 0x188 pops the receive queue. The FIFO status at 0x014 shows RX empty in bit 0, RX full in bit 1, TX empty in bit 2 and TX full in bit 3. A push into a full transmit queue drops the word and sets bit 7. A read of an empty receive queue returns 0 and sets bit 4.
- R3: A write to the command register at 0x000 with bit 31 set, while idle, shifts one word of (bits 4:0)+1 bits, MSB first, on `mosi`. Bit 31 reads 1 until the word has finished and then reads 0. The other command fields (bits 30:26, 21:20, 12:11, 4:0) read back as written, and all remaining bits read 0.
- R4: Command bits 29:28 set the clock mode: bit 29 is the idle level of `sclk`, and bit 28 selects sampling on the trailing edge (1) or the leading edge (0). Each half period of `sclk` lasts (divider register at 0x020, bits 7:0)+1 system clocks.
- R5: When RX enable (bit 12) is set, the captured word is pushed into the receive queue, right-aligned in its low bits, and the upper bits are zero.
- R6: Bit 30 of the transfer status at 0x010 is set when a word finishes and is cleared by writing 1 to it.
- R7: Starting a word with TX enable (bit 11) set and the transmit queue empty shifts out zeros and sets bit 6.
- R8: Finishing a word with RX enable set and the receive queue full drops the word and sets bit 5.
- R9: With TX enable clear, no entry is taken from the transmit queue and zeros are shifted out. With RX enable clear, nothing is pushed into the receive queue.
- R10: With software chip-select control (bit 21) clear, only the line picked by bits 27:26 goes low, and only while a word is in progress.
- R11: With bit 21 set, the picked line follows bit 20 (0 drives it low, 1 drives it high), and all other lines stay high.
- R12: Bits 8:4 of the FIFO status are sticky. Bit 8 is set whenever any of bits 7:4 is set. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R13: A command write that arrives while a word is in progress is ignored as a whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (pops the receive queue at 0x188) |
| regAddr | input | 9 | Byte address of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid while the address is held |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 4 | Active-low chip selects |

## Verification
The hardest state to reach from the ports is a word that completes into a full receive queue while the transmit side stays consistent. The stimulus first fills the transmit queue past its limit, then runs four back-to-back words that drain it into the receive queue. A fifth word with only RX enable set then hits the full receive queue. The serial waveform is compared cycle by cycle against a behavioural model in every clock mode and at several divider settings. A command write is also issued in the middle of a long word, so that any acceptance of it shows up as a change in chip select or clock level.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int WORD_W  = 32;
  localparam int LEN_W   = 5;
  localparam int NUM_CS  = 4;

  localparam int OFF_CMD = 'h000;
  localparam int OFF_XS  = 'h010;
  localparam int OFF_FS  = 'h014;
  localparam int OFF_DIV = 'h020;
  localparam int OFF_TXF = 'h108;
  localparam int OFF_RXF = 'h188;

  localparam logic [WORD_W-1:0] CMD_MASK = 32'h7C30_181F;

  typedef struct packed {
    logic              start;
    logic [WORD_W-1:0] txWord;
    logic [LEN_W-1:0]  lenM1;
    logic              cpol;
    logic              cpha;
    logic              idleCpol;
  } spim_cmd_t;

  typedef struct packed {
    logic              busy;
    logic              done;
    logic [WORD_W-1:0] rxWord;
  } spim_evt_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    rdPtr, wrPtr;
  logic [CNT_W-1:0] count;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wdata;
  end

  assign rdata = mem[rdPtr];
  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));

  AST_FIFO_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rstN) push |-> !full); // R2
  AST_FIFO_POP_DATA: assert property (@(posedge clk) disable iff (!rstN) pop |-> !empty); // R2
endmodule

// File: rtl/spim_datapath.sv
module spim_datapath
  import spim_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  spim_cmd_t        cmd,
  input  logic [DIV_W-1:0] div,
  output spim_evt_t        evt,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  localparam int EDGE_W = LEN_W + 1;

  logic              busyQ, finQ, sclkR, cpolQ, cphaQ;
  logic [LEN_W-1:0]  lenM1Q;
  logic [DIV_W-1:0]  divQ, halfCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic [WORD_W-1:0] shOut, shIn;
  logic              tick, sampleNow, shiftNow, lastEdge;

  assign tick      = busyQ && !finQ && (halfCnt == divQ);
  assign sampleNow = tick && (edgeCnt[0] == cphaQ);
  assign shiftNow  = tick && (edgeCnt[0] != cphaQ) && !(cphaQ && edgeCnt == '0);
  assign lastEdge  = (edgeCnt == {lenM1Q, 1'b1});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      finQ    <= 1'b0;
      sclkR   <= 1'b0;
      cpolQ   <= 1'b0;
      cphaQ   <= 1'b0;
      lenM1Q  <= '0;
      divQ    <= '0;
      halfCnt <= '0;
      edgeCnt <= '0;
      shOut   <= '0;
      shIn    <= '0;
    end else if (finQ) begin
      finQ  <= 1'b0;
      busyQ <= 1'b0;
    end else if (!busyQ) begin
      if (cmd.start) begin
        busyQ   <= 1'b1;
        sclkR   <= cmd.cpol;
        cpolQ   <= cmd.cpol;
        cphaQ   <= cmd.cpha;
        lenM1Q  <= cmd.lenM1;
        divQ    <= div;
        halfCnt <= '0;
        edgeCnt <= '0;
        shOut   <= cmd.txWord << (LEN_W'(WORD_W - 1) - cmd.lenM1);
        shIn    <= '0;
      end
    end else if (tick) begin
      halfCnt <= '0;
      sclkR   <= ~sclkR;
      edgeCnt <= edgeCnt + 1'b1;
      if (sampleNow) shIn  <= {shIn[WORD_W-2:0], miso};
      if (shiftNow)  shOut <= shOut << 1;
      if (lastEdge)  finQ  <= 1'b1;
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  assign evt.busy   = busyQ;
  assign evt.done   = finQ;
  assign evt.rxWord = shIn;
  assign mosi       = busyQ & shOut[WORD_W-1];
  assign sclk       = busyQ ? sclkR : cmd.idleCpol;

  AST_DONE_AT_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN) finQ |-> (sclkR == cpolQ)); // R4
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN) cmd.start |-> !busyQ); // R13
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int FIFO_DEPTH = 4,
  parameter int DIV_W      = 8,
  parameter int DIV_RESET  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata,
  output logic [NUM_CS-1:0] csN,
  output spim_cmd_t         cmd,
  output logic [DIV_W-1:0]  divOut,
  input  spim_evt_t         evt
);
  logic [WORD_W-1:0] cmdReg;
  logic [DIV_W-1:0]  divReg;
  logic              ready;
  logic [4:0]        stk;   // {err, txOvf, txUnd, rxOvf, rxUnd}
  logic wrCmd, wrXs, wrFs, wrDiv, wrTx, rdRx, start;
  logic txPush, txPop, txEmpty, txFull, rxPush, rxPop, rxEmpty, rxFull;
  logic txOvf, txUnd, rxOvf, rxUnd;
  logic [WORD_W-1:0] txHead, rxHead;
  logic [4:0] setV, clrV;

  assign wrCmd = regWr && (regAddr == ADDR_W'(OFF_CMD));
  assign wrXs  = regWr && (regAddr == ADDR_W'(OFF_XS));
  assign wrFs  = regWr && (regAddr == ADDR_W'(OFF_FS));
  assign wrDiv = regWr && (regAddr == ADDR_W'(OFF_DIV));
  assign wrTx  = regWr && (regAddr == ADDR_W'(OFF_TXF));
  assign rdRx  = regRd && (regAddr == ADDR_W'(OFF_RXF));

  assign start  = wrCmd && !evt.busy && regWdata[31];
  assign txPop  = start && regWdata[11] && !txEmpty;
  assign txUnd  = start && regWdata[11] && txEmpty;
  assign txPush = wrTx && !txFull;
  assign txOvf  = wrTx && txFull;
  assign rxPush = evt.done && cmdReg[12] && !rxFull;
  assign rxOvf  = evt.done && cmdReg[12] && rxFull;
  assign rxPop  = rdRx && !rxEmpty;
  assign rxUnd  = rdRx && rxEmpty;

  assign setV = {txOvf | txUnd | rxOvf | rxUnd, txOvf, txUnd, rxOvf, rxUnd};
  assign clrV = wrFs ? regWdata[8:4] : 5'b0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= '0;
      divReg <= DIV_W'(DIV_RESET);
      ready  <= 1'b0;
      stk    <= '0;
    end else begin
      if (wrCmd && !evt.busy) cmdReg <= regWdata & CMD_MASK;
      if (wrDiv) divReg <= regWdata[DIV_W-1:0];
      ready <= evt.done | (ready & ~(wrXs & regWdata[30]));
      stk   <= setV | (stk & ~clrV);
    end
  end

  spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) i_txFifo (
    .clk(clk), .rstN(rstN), .push(txPush), .wdata(regWdata), .pop(txPop),
    .rdata(txHead), .empty(txEmpty), .full(txFull));

  spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) i_rxFifo (
    .clk(clk), .rstN(rstN), .push(rxPush), .wdata(evt.rxWord), .pop(rxPop),
    .rdata(rxHead), .empty(rxEmpty), .full(rxFull));

  assign cmd.start    = start;
  assign cmd.txWord   = txPop ? txHead : '0;
  assign cmd.lenM1    = regWdata[LEN_W-1:0];
  assign cmd.cpol     = regWdata[29];
  assign cmd.cpha     = regWdata[28];
  assign cmd.idleCpol = cmdReg[29];
  assign divOut       = divReg;

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(OFF_CMD))      regRdata = cmdReg | {evt.busy, 31'b0};
    else if (regAddr == ADDR_W'(OFF_XS))  regRdata = {1'b0, ready, 30'b0};
    else if (regAddr == ADDR_W'(OFF_FS))  regRdata = {23'b0, stk, txFull, txEmpty, rxFull, rxEmpty};
    else if (regAddr == ADDR_W'(OFF_DIV)) regRdata = WORD_W'(divReg);
    else if (regAddr == ADDR_W'(OFF_RXF)) regRdata = rxEmpty ? '0 : rxHead;
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign csN[i] = !((cmdReg[27:26] == 2'(i)) && (cmdReg[21] ? !cmdReg[20] : evt.busy));
  end

  AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (!rstN) evt.done |=> ready); // R6
  AST_UNDERRUN_FLAG: assert property (@(posedge clk) disable iff (!rstN) (start && regWdata[11] && txEmpty) |=> stk[2]); // R7
  AST_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rstN) (evt.done && cmdReg[12] && rxFull) |=> (stk[1] && stk[4])); // R8
  AST_ONE_CS_LOW: assert property (@(posedge clk) disable iff (!rstN) $onehot0(~csN)); // R10
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs
  import spim_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int FIFO_DEPTH = 4,
  parameter int DIV_W      = 8,
  parameter int DIV_RESET  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [3:0]        csN
);
  spim_cmd_t        cmd;
  spim_evt_t        evt;
  logic [DIV_W-1:0] div;

  spim_ctrl #(.ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH), .DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .csN(csN), .cmd(cmd),
    .divOut(div), .evt(evt));

  spim_datapath #(.DIV_W(DIV_W)) i_datapath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .div(div), .evt(evt),
    .sclk(sclk), .mosi(mosi), .miso(miso));
endmodule

// File: tb/test_spi_master_regs.sv
module test_spi_master_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [8:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        sclk, mosi, miso = 1'b0;
  logic [3:0]  csN;

  int checks = 0, fails = 0;

  // behavioural reference state
  bit mOn = 0, mCpol = 0, mCpha = 0, mSw = 0, mSwVal = 0, mTxEn = 0, mRxEn = 0, mReady = 0;
  int mK = 0, mL = 1, mD = 0, mSel = 0, mDiv = 1;
  logic [31:0] mTx = '0, mSlv = '0, mCmd = '0;
  logic [31:0] txQ[$], rxQ[$];
  bit eRxU = 0, eRxO = 0, eTxU = 0, eTxO = 0, eErr = 0;

  spi_master_regs i_spi_master_regs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .csN(csN));

  always #10 clk = ~clk;

  function automatic bit mBusy(int k);
    return mOn && (k >= 0) && (k <= 2 * mL * (mD + 1));
  endfunction

  // cycle-by-cycle comparison of the serial pins (R3, R4, R10, R11)
  always @(negedge clk) begin
    int e, b;
    bit busyE, sclkE, mosiE, misoE;
    logic [3:0] csE;
    if (rstN) begin
      busyE = mBusy(mK);
      sclkE = mCpol; mosiE = 0; misoE = 0;
      if (busyE) begin
        e = mK / (mD + 1);
        if (e > 2 * mL) e = 2 * mL;
        sclkE = mCpol ^ e[0];
        b = mCpha ? ((e == 0) ? 0 : (e - 1) / 2) : e / 2;
        if (b < mL) begin
          mosiE = mTx[mL - 1 - b];
          misoE = mSlv[mL - 1 - b];
        end
      end
      csE = 4'hF;
      if (mSw) csE[mSel] = mSwVal;
      else if (busyE) csE[mSel] = 1'b0;
      miso = misoE;
      checks++;
      if (sclk !== sclkE || mosi !== mosiE || csN !== csE) begin
        fails++;
        $display("FAIL R3/R4/R10/R11 wave k=%0d: actual sclk=%b mosi=%b csN=%h expected sclk=%b mosi=%b csN=%h",
                 mK, sclk, mosi, csN, sclkE, mosiE, csE);
      end
      mK++;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int addr, logic [31:0] data);
    @(negedge clk);
    regAddr = 9'(addr); regWdata = data; regWr = 1'b1;
    @(posedge clk); #1;
    regWr = 1'b0;
  endtask

  task automatic rd(int addr, output logic [31:0] data);
    @(negedge clk);
    regAddr = 9'(addr); regRd = 1'b1;
    #2 data = regRdata;
    @(posedge clk); #1;
    regRd = 1'b0;
  endtask

  function automatic logic [31:0] fsExp();
    return {23'b0, eErr, eTxO, eTxU, eRxO, eRxU,
            txQ.size() == 4, txQ.size() == 0, rxQ.size() == 4, rxQ.size() == 0};
  endfunction

  task automatic pushTx(logic [31:0] w);
    wr('h108, w);
    if (txQ.size() < 4) txQ.push_back(w);
    else begin eTxO = 1; eErr = 1; end
  endtask

  task automatic popRx(string tag);
    logic [31:0] v, exp;
    rd('h188, v);
    if (rxQ.size() == 0) begin exp = 0; eRxU = 1; eErr = 1; end
    else exp = rxQ.pop_front();
    check(tag, v, exp);
  endtask

  task automatic chkFs(string tag);
    logic [31:0] v;
    rd('h014, v);
    check(tag, v, fsExp());
  endtask

  task automatic clrFs(logic [31:0] v);
    wr('h014, v);
    if (v[4]) eRxU = 0;
    if (v[5]) eRxO = 0;
    if (v[6]) eTxU = 0;
    if (v[7]) eTxO = 0;
    if (v[8]) eErr = 0;
  endtask

  task automatic setDiv(int d);
    wr('h020, 32'(d));
    mDiv = d;
  endtask

  // command write with reference update (ignored while busy: R13)
  task automatic cmdWr(logic [31:0] v, logic [31:0] slv);
    logic [31:0] w;
    logic [63:0] msk;
    @(negedge clk);
    regAddr = 9'h000; regWdata = v; regWr = 1'b1;
    @(posedge clk);
    if (!mBusy(mK - 1)) begin
      mCmd = v & 32'h7C30_181F;
      mCpol = v[29]; mSel = int'(v[27:26]); mSw = v[21]; mSwVal = v[20];
      mTxEn = v[11]; mRxEn = v[12];
      if (v[31]) begin
        mL = int'(v[4:0]) + 1; mD = mDiv; mCpha = v[28]; mSlv = slv;
        w = '0;
        if (mTxEn) begin
          if (txQ.size() == 0) begin eTxU = 1; eErr = 1; end
          else w = txQ.pop_front();
        end
        mTx = w;
        msk = (64'd1 << mL) - 64'd1;
        if (mRxEn) begin
          if (rxQ.size() < 4) rxQ.push_back(slv & msk[31:0]);
          else begin eRxO = 1; eErr = 1; end
        end
        mReady = 1;
        mK = 0; mOn = 1;
      end
    end
    #1 regWr = 1'b0;
  endtask

  task automatic waitDone();
    repeat (2 * mL * (mD + 1) + 4) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    rd('h000, v); check("R1 cmd", v, 0);
    rd('h010, v); check("R1 xfer status", v, 0);
    rd('h014, v); check("R1 fifo status", v, 32'h5);
    check("R1 pins", {28'b0, csN}, 32'hF);

    // long word, mode 0, divider 1, cs 1
    setDiv(1);
    pushTx(32'hA5C3_0F96);
    chkFs("R2 tx not empty");
    cmdWr(32'h8400_181F, 32'h3C5A_9E71);
    repeat (10) @(posedge clk);
    rd('h000, v); check("R3 go while busy", v, 32'h8400_181F);
    cmdWr(32'h2830_0000, 0);               // R13: must be ignored
    rd('h000, v); check("R13 cmd unchanged", v, 32'h8400_181F);
    waitDone();
    rd('h000, v); check("R3 go cleared", v, mCmd);
    rd('h010, v); check("R6 ready set", v, 32'h4000_0000);
    wr('h010, 32'h4000_0000); mReady = 0;
    rd('h010, v); check("R6 ready cleared", v, 0);
    popRx("R5 rx word 32b");
    chkFs("R2 fifo status idle");

    // mode 3, 8 bits, divider 0, cs 3
    setDiv(0);
    pushTx(32'h0000_01B3);
    cmdWr(32'hBC00_1807, 32'hFFFF_FF4D);
    waitDone();
    popRx("R5 R4 mode3 8b");

    // mode 1, 13 bits, divider 2, cs 0
    setDiv(2);
    pushTx(32'h0000_1ABC);
    cmdWr(32'h9000_180C, 32'h0000_0B5E);
    waitDone();
    popRx("R4 mode1 13b");

    // mode 2, 1 bit, divider 1, cs 2
    setDiv(1);
    pushTx(32'h1);
    cmdWr(32'hA800_1800, 32'h1);
    waitDone();
    popRx("R4 mode2 1b");
    cmdWr(32'h0, 0);

    // R7 underrun
    cmdWr(32'h8000_180F, 32'h0000_C3A5);
    waitDone();
    chkFs("R7 tx underrun flag");
    popRx("R7 rx after underrun");

    // R12 write-one-to-clear
    clrFs(32'h0);     chkFs("R12 write 0 keeps");
    clrFs(32'h40);    chkFs("R12 clear bit6");
    clrFs(32'h100);   chkFs("R12 clear bit8");

    // R2 tx overflow
    for (int i = 0; i < 5; i++) pushTx(32'h1000_0000 + 32'(i) * 32'h0101_0101);
    chkFs("R2 tx overflow");

    // R9 both enables off
    setDiv(0);
    cmdWr(32'h8000_0007, 32'hFF);
    waitDone();
    chkFs("R9 queues untouched");
    clrFs(32'h1F0);
    chkFs("R12 clear all");

    // R8 rx overflow
    for (int i = 0; i < 4; i++) begin
      cmdWr(32'h8000_181F, 32'h8765_4321 ^ (32'(i) << 8));
      waitDone();
    end
    cmdWr(32'h8000_101F, 32'hDEAD_BEEF);
    waitDone();
    chkFs("R8 rx overflow");
    for (int i = 0; i < 4; i++) popRx("R8 kept words");
    popRx("R2 rx underrun");
    chkFs("R2 rx underrun flag");
    clrFs(32'h1F0);

    // R11 software chip select
    cmdWr(32'h0830_0000, 0);
    check("R11 sw cs high", {28'b0, csN}, 32'hF);
    cmdWr(32'h0820_0000, 0);
    check("R11 sw cs low", {28'b0, csN}, 32'hB);
    pushTx(32'h0000_5A5A);
    cmdWr(32'h8820_180F, 32'h0000_1234);
    waitDone();
    popRx("R11 transfer under sw cs");
    cmdWr(32'h0830_0000, 0);
    check("R11 sw cs released", {28'b0, csN}, 32'hF);

    // R4 idle level
    cmdWr(32'h2000_0000, 0);
    @(negedge clk);
    check("R4 idle high", {31'b0, sclk}, 1);
    cmdWr(32'h0, 0);
    @(negedge clk);
    check("R4 idle low", {31'b0, sclk}, 0);
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule